// File: doc/BRIEF.md
# Data-Space Access Router with Wait States

This block sits between a CPU core's data-space load/store port and two memories. Each accepted request carries a 16-bit byte address, a read/write flag and write data. Addresses in the low internal window (0x0000 up to and including 0x21FF) go to an internal memory port. Addresses from 0x2200 upward go to an external SRAM bus with active-low read and write strobes, provided external memory is switched on. The core uses one request interface for both targets and learns from a `stall` output how many extra cycles the access cost.

Two configuration inputs govern the external path. `ext_en` switches external SRAM on. The 2-bit `wait_sel` field picks 0 to 3 wait states. Both are sampled when a request is accepted. An internal access finishes one cycle after acceptance with no stall. An external access holds `stall` high for `wait_sel + 1` cycles and then finishes. With external memory switched off, an access above the internal window finishes like an internal one but touches nothing. A read of such an address returns 0x00.

The controller is a five-state machine:
- `S_IDLE`: no access.
- `S_INT`: one cycle on the internal port.
- `S_EXT`: strobe active, counting the wait states down.
- `S_DONE`: external access finished, captured byte presented.
- `S_NULL`: disabled external access finished.

From `S_IDLE`, `S_INT`, `S_DONE` or `S_NULL`, an accepted request moves to `S_INT` (internal address), `S_EXT` (external address with `ext_en` set) or `S_NULL` (external address with `ext_en` clear). With no request these states return to `S_IDLE`. `S_EXT` stays in `S_EXT` while the wait counter is non-zero and moves to `S_DONE` when it reaches zero.

Top module: `dspace_router`

## Requirements
- R1: A request with an address below 0x2200 is routed to the internal port. `int_en` is high for exactly one cycle, the cycle after acceptance. `stall` stays low, and for a read `rd_data` carries the internal byte in that cycle.
- R2: A request with an address of 0x2200 or above, with `ext_en` set, is served by the external SRAM bus. Writes land in external memory and reads return the external byte.
- R3: During an internal access `ext_rd_n` and `ext_wr_n` both stay high.
- R4: With `ext_en` clear, an access at or above 0x2200 drives no strobe and raises no stall. It drops a write and returns 0x00 for a read, one cycle after acceptance.
- R5: With `wait_sel` = W (0, 1, 2 or 3), an external access holds `stall` high for exactly W+1 consecutive cycles, starting the cycle after acceptance.
- R6: `done` is high in the single cycle an access completes. For an external read, `rd_data` holds the SRAM byte in the cycle `stall` falls.
- R7: For an external access, the matching strobe (`ext_rd_n` for a read, `ext_wr_n` for a write) is low in exactly the `stall` cycles and the other strobe stays high. `ext_addr` and `ext_wdata` stay stable while the strobe is low, and the read byte is sampled on the strobe's last cycle.
- R8: A request presented while `stall` is high is ignored and has no effect on either memory.
- R9: After reset `stall`, `done` and `int_en` are low and both strobes are high.
- R10: `ext_en` and `wait_sel` are sampled at acceptance. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_en | input | 1 | External SRAM enable |
| wait_sel | input | 2 | Wait states for external accesses (0..3) |
| req_valid | input | 1 | Core request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space byte address |
| req_wdata | input | 8 | Write byte |
| stall | output | 1 | Core must wait; high for each extra cycle |
| done | output | 1 | Access completes this cycle |
| rd_data | output | 8 | Read byte, valid with `done` |
| int_en | output | 1 | Internal port access cycle |
| int_we | output | 1 | Internal port write |
| int_addr | output | 16 | Internal port address |
| int_wdata | output | 8 | Internal port write byte |
| int_rdata | input | 8 | Internal port read byte (combinational) |
| ext_addr | output | 16 | External SRAM address |
| ext_wdata | output | 8 | External SRAM write byte |
| ext_rdata | input | 8 | External SRAM read byte |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
The bench builds the router with its defaults: a 16-bit address, 8-bit data, the internal window ending at 0x2200 and a 2-bit wait field. This places the 0x21FF/0x2200 boundary and the top address 0xFFFF in the directed cases, along with every one of the four wait settings. Random traffic concentrates addresses near the boundary and mixes enabled and disabled external accesses. Stray requests are injected while `stall` is high, and the configuration inputs are changed during accesses.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INT,
        S_EXT,
        S_DONE,
        S_NULL
    } dsp_state_e;

    typedef enum logic [1:0] {
        RG_INT,
        RG_EXT,
        RG_OFF
    } dsp_region_e;

endpackage

// File: rtl/dspace_decode.sv
module dspace_decode
    import dspace_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int unsigned INT_LIMIT = 32'h2200
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_on,
    output dsp_region_e       region
);

    localparam logic [ADDR_W:0] LIMIT = INT_LIMIT[ADDR_W:0];

    logic below;

    assign below = ({1'b0, addr} < LIMIT);

    always_comb begin
        if (below) begin
            region = RG_INT;
        end else if (ext_on) begin
            region = RG_EXT;
        end else begin
            region = RG_OFF;
        end
    end

endmodule

// File: rtl/dspace_waitcnt.sv
module dspace_waitcnt #(
    parameter int WS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WS_W-1:0] ws,
    input  logic            dec,
    output logic            zero
);

    logic [WS_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= ws;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R5: each counting step removes exactly one wait state
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !load |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/dspace_ctrl.sv
module dspace_ctrl
    import dspace_pkg::*;
#(
    parameter int WS_W = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  dsp_region_e region,
    input  logic        cnt_zero,
    output logic        accept,
    output logic        cnt_load,
    output logic        cnt_dec,
    output logic        capture,
    output logic        stall,
    output logic        done,
    output logic        int_sel,
    output logic        ext_fin
);

    localparam int RUN_W   = WS_W + 2;
    localparam int MAX_RUN = 1 << WS_W;

    dsp_state_e state, state_nx;

    assign accept = req_valid && (state != S_EXT);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_EXT: begin
                state_nx = cnt_zero ? S_DONE : S_EXT;
            end
            S_IDLE, S_INT, S_DONE, S_NULL: begin
                if (accept) begin
                    unique case (region)
                        RG_INT:  state_nx = S_INT;
                        RG_EXT:  state_nx = S_EXT;
                        RG_OFF:  state_nx = S_NULL;
                        default: state_nx = S_NULL;
                    endcase
                end else begin
                    state_nx = S_IDLE;
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        stall    = 1'b0;
        done     = 1'b0;
        int_sel  = 1'b0;
        ext_fin  = 1'b0;
        capture  = 1'b0;
        cnt_dec  = 1'b0;
        cnt_load = accept && (region == RG_EXT);
        unique case (state)
            S_IDLE: ;
            S_INT: begin
                int_sel = 1'b1;
                done    = 1'b1;
            end
            S_EXT: begin
                stall   = 1'b1;
                capture = cnt_zero;
                cnt_dec = !cnt_zero;
            end
            S_DONE: begin
                ext_fin = 1'b1;
                done    = 1'b1;
            end
            S_NULL: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (stall) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R5: a stall never outlasts the largest wait setting plus one
    a_r5_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> run_len < MAX_RUN[RUN_W-1:0]);

    // R8: no request is taken while the core is stalled
    a_r8_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !cnt_load);

    // R4: a disabled external access never raises stall
    a_r4_off_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        accept && region == RG_OFF |=> !stall && done);

endmodule

// File: rtl/dspace_datapath.sv
module dspace_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic [DATA_W-1:0] int_rdata,
    input  logic              int_sel,
    input  logic              ext_fin,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              lat_we,
    output logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cap_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_we    <= 1'b0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_we    <= req_we;
            lat_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_data <= '0;
        end else if (capture && !lat_we) begin
            cap_data <= ext_rdata;
        end
    end

    always_comb begin
        if (int_sel) begin
            rd_data = int_rdata;
        end else if (ext_fin) begin
            rd_data = cap_data;
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/dspace_router.sv
module dspace_router
    import dspace_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          WS_W      = 2,
    parameter int unsigned INT_LIMIT = 32'h2200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_en,
    input  logic [WS_W-1:0]   wait_sel,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              stall,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              int_en,
    output logic              int_we,
    output logic [ADDR_W-1:0] int_addr,
    output logic [DATA_W-1:0] int_wdata,
    input  logic [DATA_W-1:0] int_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              ext_rd_n,
    output logic              ext_wr_n
);

    dsp_region_e       region;
    logic              accept;
    logic              cnt_load;
    logic              cnt_dec;
    logic              cnt_zero;
    logic              capture;
    logic              int_sel;
    logic              ext_fin;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_we;
    logic [DATA_W-1:0] lat_wdata;

    dspace_decode #(
        .ADDR_W    (ADDR_W),
        .INT_LIMIT (INT_LIMIT)
    ) u_decode (
        .addr   (req_addr),
        .ext_on (ext_en),
        .region (region)
    );

    dspace_waitcnt #(
        .WS_W (WS_W)
    ) u_waitcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .ws    (wait_sel),
        .dec   (cnt_dec),
        .zero  (cnt_zero)
    );

    dspace_ctrl #(
        .WS_W (WS_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .region    (region),
        .cnt_zero  (cnt_zero),
        .accept    (accept),
        .cnt_load  (cnt_load),
        .cnt_dec   (cnt_dec),
        .capture   (capture),
        .stall     (stall),
        .done      (done),
        .int_sel   (int_sel),
        .ext_fin   (ext_fin)
    );

    dspace_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .ext_rdata (ext_rdata),
        .int_rdata (int_rdata),
        .int_sel   (int_sel),
        .ext_fin   (ext_fin),
        .lat_addr  (lat_addr),
        .lat_we    (lat_we),
        .lat_wdata (lat_wdata),
        .rd_data   (rd_data)
    );

    assign int_en    = int_sel;
    assign int_we    = int_sel && lat_we;
    assign int_addr  = lat_addr;
    assign int_wdata = lat_wdata;

    assign ext_addr  = lat_addr;
    assign ext_wdata = lat_wdata;
    assign ext_rd_n  = !(stall && !lat_we);
    assign ext_wr_n  = !(stall && lat_we);

    // R3: internal port cycles keep the external strobes idle
    a_r3_int_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        int_en |-> ext_rd_n && ext_wr_n);

    // R7: exactly one strobe is active in every stall cycle
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ext_rd_n != ext_wr_n));

    // R7: external address and write byte hold while a strobe is active
    a_r7_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall && $past(stall) |-> $stable(ext_addr) && $stable(ext_wdata));

    // R6: the cycle after the last stall cycle completes the access
    a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> done);

    // R9: nothing is active while reset is held
    always_comb begin
        if (!rst_n) begin
            a_r9_reset_idle: assert (!stall && !done && !int_en);
        end
    end

endmodule

// File: tb/sim_dspace_router.sv
module sim_dspace_router;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0;
    logic [1:0]  wait_sel = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        stall, done, int_en, int_we, ext_rd_n, ext_wr_n;
    logic [7:0]  rd_data, int_wdata, int_rdata, ext_wdata, ext_rdata;
    logic [15:0] int_addr, ext_addr;

    int n_run = 0;
    int n_fail = 0;

    logic [7:0] imem [256];
    logic [7:0] xmem [256];
    logic [7:0] ref_i [256];
    logic [7:0] ref_x [256];

    always #(CLK_P/2) clk = ~clk;

    dspace_router u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_en    (ext_en),
        .wait_sel  (wait_sel),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .stall     (stall),
        .done      (done),
        .rd_data   (rd_data),
        .int_en    (int_en),
        .int_we    (int_we),
        .int_addr  (int_addr),
        .int_wdata (int_wdata),
        .int_rdata (int_rdata),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .ext_rdata (ext_rdata),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n)
    );

    assign int_rdata = imem[int_addr[7:0]];
    assign ext_rdata = (!ext_rd_n) ? xmem[ext_addr[7:0]] : 8'h00;

    always @(posedge clk) begin
        if (int_en && int_we) imem[int_addr[7:0]] <= int_wdata;
        if (!ext_wr_n) xmem[ext_addr[7:0]] <= ext_wdata;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_stall(input logic [15:0] a, input bit en, input logic [1:0] ws);
        if (a < 16'h2200) return 0;
        if (!en) return 0;
        return int'(ws) + 1;
    endfunction

    function automatic logic [7:0] exp_read(input logic [15:0] a, input bit en);
        if (a < 16'h2200) return ref_i[a[7:0]];
        if (!en) return 8'h00;
        return ref_x[a[7:0]];
    endfunction

    task automatic access(input bit we, input logic [15:0] a, input logic [7:0] d,
                          input bit en, input logic [1:0] ws, input bit inject);
        int nst = 0;
        int nstb = 0;
        int nint = 0;
        int kdone = -1;
        logic [7:0] got = 8'h00;
        bit is_int = (a < 16'h2200);
        int est = exp_stall(a, en, ws);
        logic [7:0] erd = exp_read(a, en);
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        ext_en    = en;
        wait_sel  = ws;
        @(negedge clk);
        req_valid = 1'b0;
        ext_en    = 1'($urandom);   // R10: changes after acceptance
        wait_sel  = 2'($urandom);
        for (int k = 0; k < 12; k++) begin
            if (stall) nst++;
            if (!ext_rd_n || !ext_wr_n) nstb++;
            if (int_en) nint++;
            if (inject && stall && nst == 1) begin
                req_valid = 1'b1;
                req_we    = 1'b1;
                req_addr  = a;
                req_wdata = ~d;
            end else begin
                req_valid = 1'b0;
            end
            if (done) begin
                kdone = k;
                got   = rd_data;
                break;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (is_int) begin
            chk("R1 int_en cycles", nint, 1);
            chk("R1 no stall internal", nst, 0);
            chk("R3 strobes during internal", nstb, 0);
        end else if (en) begin
            chk("R5 stall cycles", nst, est);
            chk("R7 strobe cycles", nstb, est);
            chk("R2 no internal cycle", nint, 0);
            chk("R6 done at stall fall", kdone, est);
        end else begin
            chk("R4 no stall when off", nst, 0);
            chk("R4 no strobe when off", nstb, 0);
            chk("R4 no internal cycle", nint, 0);
        end
        if (inject) chk("R8 stall unchanged by stray request", nst, est);
        if (!we) begin
            if (is_int) chk("R1 internal read data", int'(got), int'(erd));
            else if (en) chk("R2 R6 external read data", int'(got), int'(erd));
            else chk("R4 disabled read zero", int'(got), int'(erd));
        end else begin
            if (is_int) ref_i[a[7:0]] = d;
            else if (en) ref_x[a[7:0]] = d;
        end
        if (kdone < 0) chk("R6 access never completed", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R6 watchdog actual=hung expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] a;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) begin
            imem[i]  = 8'(i) ^ 8'h5A;
            ref_i[i] = 8'(i) ^ 8'h5A;
            xmem[i]  = 8'(i * 3);
            ref_x[i] = 8'(i * 3);
        end
        repeat (3) @(negedge clk);
        chk("R9 stall in reset", int'(stall), 0);
        chk("R9 done in reset", int'(done), 0);
        chk("R9 int_en in reset", int'(int_en), 0);
        chk("R9 rd strobe in reset", int'(ext_rd_n), 1);
        chk("R9 wr strobe in reset", int'(ext_wr_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 stall after reset", int'(stall), 0);
        chk("R9 strobes after reset", int'(ext_rd_n && ext_wr_n), 1);

        // directed boundary cases
        access(1'b1, 16'h21FF, 8'hA1, 1'b1, 2'd0, 1'b0);
        access(1'b0, 16'h21FF, 8'h00, 1'b1, 2'd3, 1'b0);
        access(1'b1, 16'h2200, 8'hB2, 1'b1, 2'd0, 1'b0);
        access(1'b0, 16'h2200, 8'h00, 1'b1, 2'd0, 1'b0);
        access(1'b1, 16'hFFFF, 8'hC3, 1'b1, 2'd3, 1'b0);
        access(1'b0, 16'hFFFF, 8'h00, 1'b1, 2'd3, 1'b0);
        access(1'b0, 16'h0000, 8'h00, 1'b0, 2'd2, 1'b0);
        for (int w = 0; w < 4; w++) begin
            access(1'b1, 16'h4010, 8'(8'h10 + w), 1'b1, 2'(w), 1'b0);
            access(1'b0, 16'h4010, 8'h00, 1'b1, 2'(w), 1'b0);
        end
        // R4: disabled write dropped, then read back with external enabled
        access(1'b1, 16'h3033, 8'hEE, 1'b0, 2'd1, 1'b0);
        access(1'b0, 16'h3033, 8'h00, 1'b0, 2'd1, 1'b0);
        access(1'b0, 16'h3033, 8'h00, 1'b1, 2'd1, 1'b0);
        // R8: stray write during stall, then read back
        access(1'b1, 16'h5044, 8'h3C, 1'b1, 2'd2, 1'b1);
        access(1'b0, 16'h5044, 8'h00, 1'b1, 2'd0, 1'b0);
        access(1'b0, 16'h6055, 8'h77, 1'b1, 2'd3, 1'b1);
        access(1'b0, 16'h6055, 8'h00, 1'b1, 2'd0, 1'b0);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [1:0] ws = 2'($urandom);
            bit en = ($urandom % 4) != 0;
            case ($urandom % 4)
                0: a = 16'h2200 - 16'(($urandom % 8) + 1);
                1: a = 16'h2200 + 16'($urandom % 8);
                2: a = 16'($urandom % 16'h2200);
                default: a = 16'h2200 + 16'($urandom % 16'hDE00);
            endcase
            access(1'($urandom), a, 8'($urandom), en, ws,
                   (ws != 2'd0) && (($urandom % 3) == 0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule